// File: doc/BRIEF.md
# Loadable Binary Sorting-Network Checker

This block decides whether a comparator network, supplied at run time, sorts every input of a fixed channel count. A host streams the comparator list in as bytes, one byte per cycle on a valid/data pair that a UART receiver would drive. Once the last comparator has arrived, the block drives every binary vector of the channel count through the loaded network and tests each result for order. The 0-1 principle makes this enough to prove a comparator network correct for all inputs.

Each comparator is held in a register, so a new candidate needs only a new byte stream and no rebuild of the logic. With one-bit channels, a comparator reduces to an AND gate feeding the lower channel and an OR gate feeding the higher one. Every comparator slot is one pipeline stage. A tag holding the source vector travels alongside the data, so that a failure is reported against the vector that caused it. The scan halts at the first unsorted result and latches that vector. If no result is unsorted, the scan ends after the all-ones vector and the block reports a pass.

Top module: `sortnet_checker`

## Requirements
- R1: After reset, `done`, `pass` and `fail` are low and `fail_vec` is zero.
- R2: Load protocol. While no scan is running, the byte 0x5A opens a load. All other bytes received while no load is open are ignored. The byte after 0x5A is the comparator count. Each comparator then follows as two bytes, and only the low log2(N_CH) bits of each byte are used as a channel index. A scan begins once the last comparator byte has arrived, or straight after the count byte when the count is zero.
- R3: A comparator writes the AND of its two channels to the lower-numbered channel and the OR to the higher-numbered one, whichever of its two bytes carried the lower index. A comparator whose two indices are equal leaves the vector unchanged, as does every slot at or beyond the loaded count.
- R4: Comparators act in the order they were loaded.
- R5: The scan applies the vectors 0 to 2^N_CH-1 in ascending order, with vector bit k on channel k.
- R6: A network output counts as sorted when no channel k holds 1 while channel k+1 holds 0. When every vector up to and including all-ones sorts, `done` and `pass` rise and `fail` stays low.
- R7: On the first unsorted output, `done` and `fail` rise and `fail_vec` holds the smallest input vector that failed. That value then stays fixed until the next scan starts.
- R8: A 0x5A byte that arrives while a scan is running neither opens a load nor alters the running scan.
- R9: A count byte larger than MAX_CMP is taken as MAX_CMP, and the load ends after MAX_CMP comparators.
- R10: `done`, `pass`, `fail` and `fail_vec` keep their values through idle bytes and are cleared when the next scan starts.
- R11: `pass` and `fail` are never high together, and neither one is high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_valid | input | 1 | Marks a received byte on `rx_data` for one cycle |
| rx_data | input | 8 | Received byte |
| done | output | 1 | The scan has finished |
| pass | output | 1 | Every vector sorted |
| fail | output | 1 | An unsorted output was found |
| fail_vec | output | N_CH | First input vector that failed |

## Verification
The bench aims at the cases where a misaligned pipeline tag would report the wrong vector. These are an empty network, which must fail at vector 1, and a full sorter with its last comparator removed, whose expected first failure comes from a bench model. Reordering the comparators of a correct sorter must produce the failure the model predicts; a design that applied comparators in the wrong order would pass or report a different vector. Loading a sorter with its index bytes swapped, and with their high bits set, must still pass, so any design that depends on byte order fails this case. A start byte sent in the middle of a scan must not restart it: a design that accepted that byte would load an empty network and report vector 1 as failing. An oversized count byte must not leave the loader stuck waiting for comparators it will never receive.

// File: rtl/sn_pkg.sv
package sn_pkg;

  localparam logic [7:0] CMD_LOAD = 8'h5A;

  typedef enum logic [2:0] {
    LD_IDLE,
    LD_COUNT,
    LD_FIRST,
    LD_SECOND,
    LD_GO
  } ld_state_e;

endpackage

// File: rtl/sn_cfg_store.sv
module sn_cfg_store
  import sn_pkg::*;
#(
  parameter int N_CH    = 8,
  parameter int MAX_CMP = 32,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_valid,
  input  logic [7:0]                 rx_data,
  input  logic                       busy,
  output logic                       go,
  output logic [MAX_CMP*IDX_W-1:0]   lo_idx,
  output logic [MAX_CMP*IDX_W-1:0]   hi_idx,
  output logic [MAX_CMP-1:0]         ent_en
);

  ld_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   ptr_q, ptr_d;
  logic [IDX_W-1:0]   first_q, first_d;
  logic               wr_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ptr_d   = ptr_q;
    first_d = first_q;
    wr_en   = 1'b0;
    unique case (state_q)
      LD_IDLE: begin
        if (rx_valid && !busy && (rx_data == CMD_LOAD)) state_d = LD_COUNT;
      end
      LD_COUNT: begin
        if (rx_valid) begin
          cnt_d   = (rx_data > 8'(MAX_CMP)) ? CNT_W'(MAX_CMP) : CNT_W'(rx_data);
          ptr_d   = '0;
          state_d = (rx_data == 8'd0) ? LD_GO : LD_FIRST;
        end
      end
      LD_FIRST: begin
        if (rx_valid) begin
          first_d = rx_data[IDX_W-1:0];
          state_d = LD_SECOND;
        end
      end
      LD_SECOND: begin
        if (rx_valid) begin
          wr_en   = 1'b1;
          ptr_d   = ptr_q + CNT_W'(1);
          state_d = ((ptr_q + CNT_W'(1)) == cnt_q) ? LD_GO : LD_FIRST;
        end
      end
      LD_GO:   state_d = LD_IDLE;
      default: state_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      cnt_q   <= '0;
      ptr_q   <= '0;
      first_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ptr_q   <= ptr_d;
      first_q <= first_d;
    end
  end

  assign go = (state_q == LD_GO);

  for (genvar k = 0; k < MAX_CMP; k++) begin : g_ent
    logic [IDX_W-1:0] a_q, b_q;
    logic             wr_k;
    logic             in_range;

    assign wr_k = wr_en && (ptr_q == CNT_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0;
        b_q <= '0;
      end else if (wr_k) begin
        a_q <= first_q;
        b_q <= rx_data[IDX_W-1:0];
      end
    end

    if (N_CH == (1 << IDX_W)) begin : g_full
      assign in_range = 1'b1;
    end else begin : g_part
      assign in_range = (32'(a_q) < N_CH) && (32'(b_q) < N_CH);
    end

    assign lo_idx[k*IDX_W +: IDX_W] = (a_q < b_q) ? a_q : b_q;
    assign hi_idx[k*IDX_W +: IDX_W] = (a_q < b_q) ? b_q : a_q;
    assign ent_en[k] = (CNT_W'(k) < cnt_q) && (a_q != b_q) && in_range;
  end

  // R8: no scan is launched while one is running
  assert_no_go_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !go);

  // R2: a scan launch always follows an accepted byte
  assert_go_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> $past(rx_valid));

endmodule

// File: rtl/sn_cmp_stage.sv
module sn_cmp_stage #(
  parameter int N_CH  = 8,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [N_CH-1:0]   in_data,
  input  logic [N_CH-1:0]   in_tag,
  input  logic              en,
  input  logic [IDX_W-1:0]  lo,
  input  logic [IDX_W-1:0]  hi,
  output logic              out_valid,
  output logic [N_CH-1:0]   out_data,
  output logic [N_CH-1:0]   out_tag
);

  logic [N_CH-1:0] data_d;

  always_comb begin
    data_d = in_data;
    if (en) begin
      data_d[lo] = in_data[lo] & in_data[hi];
      data_d[hi] = in_data[lo] | in_data[hi];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid && !flush;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_tag  <= '0;
    end else if (in_valid) begin
      out_data <= data_d;
      out_tag  <= in_tag;
    end
  end

  // R3: a comparator only moves ones between channels, never creates or drops them
  assert_ones_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_data) == $countones($past(in_data))));

endmodule

// File: rtl/sn_pipe.sv
module sn_pipe #(
  parameter int N_CH    = 8,
  parameter int MAX_CMP = 32,
  parameter int IDX_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      in_valid,
  input  logic [N_CH-1:0]           in_vec,
  input  logic [MAX_CMP*IDX_W-1:0]  lo_idx,
  input  logic [MAX_CMP*IDX_W-1:0]  hi_idx,
  input  logic [MAX_CMP-1:0]        ent_en,
  output logic                      out_valid,
  output logic [N_CH-1:0]           out_data,
  output logic [N_CH-1:0]           out_tag
);

  logic [MAX_CMP:0] vld;
  logic [N_CH-1:0]  dat [MAX_CMP+1];
  logic [N_CH-1:0]  tag [MAX_CMP+1];

  assign vld[0] = in_valid;
  assign dat[0] = in_vec;
  assign tag[0] = in_vec;

  for (genvar k = 0; k < MAX_CMP; k++) begin : g_stage
    sn_cmp_stage #(.N_CH(N_CH), .IDX_W(IDX_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .in_valid  (vld[k]),
      .in_data   (dat[k]),
      .in_tag    (tag[k]),
      .en        (ent_en[k]),
      .lo        (lo_idx[k*IDX_W +: IDX_W]),
      .hi        (hi_idx[k*IDX_W +: IDX_W]),
      .out_valid (vld[k+1]),
      .out_data  (dat[k+1]),
      .out_tag   (tag[k+1])
    );
  end

  assign out_valid = vld[MAX_CMP];
  assign out_data  = dat[MAX_CMP];
  assign out_tag   = tag[MAX_CMP];

endmodule

// File: rtl/sortnet_checker.sv
module sortnet_checker #(
  parameter int N_CH    = 8,
  parameter int MAX_CMP = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [N_CH-1:0]   fail_vec
);

  localparam int IDX_W = $clog2(N_CH);
  localparam int CNT_W = $clog2(MAX_CMP + 1);
  localparam logic [N_CH-1:0] ALL_ONES = '1;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic                      go;
  logic [MAX_CMP*IDX_W-1:0]  lo_idx, hi_idx;
  logic [MAX_CMP-1:0]        ent_en;
  logic                      pipe_v;
  logic [N_CH-1:0]           pipe_data, pipe_tag;
  logic                      unsorted;

  logic              run_q, run_d;
  logic              issue_q, issue_d;
  logic [N_CH-1:0]   vec_q, vec_d;
  logic              done_q, done_d;
  logic              pass_q, pass_d;
  logic              fail_q, fail_d;
  logic [N_CH-1:0]   fvec_q, fvec_d;

  sn_cfg_store #(
    .N_CH(N_CH), .MAX_CMP(MAX_CMP), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .busy     (run_q),
    .go       (go),
    .lo_idx   (lo_idx),
    .hi_idx   (hi_idx),
    .ent_en   (ent_en)
  );

  sn_pipe #(.N_CH(N_CH), .MAX_CMP(MAX_CMP), .IDX_W(IDX_W)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .flush     (go),
    .in_valid  (run_q && issue_q),
    .in_vec    (vec_q),
    .lo_idx    (lo_idx),
    .hi_idx    (hi_idx),
    .ent_en    (ent_en),
    .out_valid (pipe_v),
    .out_data  (pipe_data),
    .out_tag   (pipe_tag)
  );

  // a 1 directly below a 0 breaks the ascending order
  assign unsorted = |(pipe_data[N_CH-2:0] & ~pipe_data[N_CH-1:1]);

  always_comb begin
    run_d   = run_q;
    issue_d = issue_q;
    vec_d   = vec_q;
    done_d  = done_q;
    pass_d  = pass_q;
    fail_d  = fail_q;
    fvec_d  = fvec_q;
    if (go) begin
      run_d   = 1'b1;
      issue_d = 1'b1;
      vec_d   = '0;
      done_d  = 1'b0;
      pass_d  = 1'b0;
      fail_d  = 1'b0;
      fvec_d  = '0;
    end else if (run_q) begin
      if (issue_q) begin
        if (vec_q == ALL_ONES) issue_d = 1'b0;
        else                   vec_d   = vec_q + N_CH'(1);
      end
      if (pipe_v) begin
        if (unsorted) begin
          fail_d  = 1'b1;
          fvec_d  = pipe_tag;
          done_d  = 1'b1;
          run_d   = 1'b0;
          issue_d = 1'b0;
        end else if (pipe_tag == ALL_ONES) begin
          pass_d  = 1'b1;
          done_d  = 1'b1;
          run_d   = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      run_q   <= 1'b0;
      issue_q <= 1'b0;
      vec_q   <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
      fvec_q  <= '0;
    end else begin
      run_q   <= run_d;
      issue_q <= issue_d;
      vec_q   <= vec_d;
      done_q  <= done_d;
      pass_q  <= pass_d;
      fail_q  <= fail_d;
      fvec_q  <= fvec_d;
    end
  end

  assign done     = done_q;
  assign pass     = pass_q;
  assign fail     = fail_q;
  assign fail_vec = fvec_q;

  // R11: verdicts are exclusive
  assert_verdict_excl_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(pass && fail));

  // R11: a verdict only appears with done
  assert_verdict_done_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pass || fail) |-> done);

  // R7: latched failing vector holds until a new scan
  assert_fail_hold_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (fail && !go) |=> (fail && $stable(fail_vec)));

  // R5: checked tags step by one within a scan
  assert_tag_step_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (run_q && $past(run_q) && pipe_v && $past(pipe_v)) |->
      (pipe_tag == $past(pipe_tag) + N_CH'(1)));

endmodule

// File: tb/sortnet_checker_test.sv
`timescale 1ns/1ps
module sortnet_checker_test;

  localparam int N = 8;
  localparam int M = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rx_valid = 1'b0;
  logic [7:0]   rx_data = 8'h00;
  logic         done, pass, fail;
  logic [N-1:0] fail_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit over = 1'b0;
  int pa [64];
  int pb [64];

  always #2.5 clk = ~clk;

  sortnet_checker #(.N_CH(N), .MAX_CMP(M)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .done(done), .pass(pass), .fail(fail), .fail_vec(fail_vec)
  );

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference: first unsorted vector for the first np comparators, -1 if none
  function automatic int model_first_bad(input int np);
    for (int v = 0; v < (1 << N); v++) begin
      logic [N-1:0] x;
      bit bad;
      x = N'(v);
      for (int k = 0; k < np && k < M; k++) begin
        int a, b, lo, hi;
        logic l, h;
        a = pa[k] % N;
        b = pb[k] % N;
        if (a != b) begin
          lo = (a < b) ? a : b;
          hi = (a < b) ? b : a;
          l = x[lo] & x[hi];
          h = x[lo] | x[hi];
          x[lo] = l;
          x[hi] = h;
        end
      end
      bad = 1'b0;
      for (int c = 0; c < N - 1; c++) if (x[c] && !x[c+1]) bad = 1'b1;
      if (bad) return v;
    end
    return -1;
  endfunction

  task automatic make_bubble(output int np);
    np = 0;
    for (int i = 0; i < N - 1; i++)
      for (int j = 0; j < N - 1 - i; j++) begin
        pa[np] = j;
        pb[np] = j + 1;
        np++;
      end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_data  = 8'h00;
  endtask

  task automatic load_net(input int cnt, input int np, input bit swap,
                          input logic [7:0] upper);
    send_byte(8'h5A);
    send_byte(8'(cnt));
    for (int k = 0; k < np; k++) begin
      send_byte(upper | 8'(swap ? pb[k] : pa[k]));
      send_byte(upper | 8'(swap ? pa[k] : pb[k]));
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
    check(seen, req, "done within timeout", int'(done), 1);
  endtask

  task automatic expect_result(input string req, input int np);
    int exp;
    exp = model_first_bad(np);
    wait_done(req);
    check(!(pass && fail), "R11", "pass and fail exclusive", int'(pass && fail), 0);
    if (exp < 0) begin
      check(pass === 1'b1, req, "pass", int'(pass), 1);
      check(fail === 1'b0, req, "fail", int'(fail), 0);
    end else begin
      check(fail === 1'b1, req, "fail", int'(fail), 1);
      check(int'(fail_vec) == exp, req, "fail_vec", int'(fail_vec), exp);
    end
  endtask

  task automatic t_reset();
    check(done === 1'b0, "R1", "done after reset", int'(done), 0);
    check(pass === 1'b0, "R1", "pass after reset", int'(pass), 0);
    check(fail === 1'b0, "R1", "fail after reset", int'(fail), 0);
    check(fail_vec === '0, "R1", "fail_vec after reset", int'(fail_vec), 0);
  endtask

  // R6 R5: a full bubble network sorts every vector
  task automatic t_bubble();
    int np;
    make_bubble(np);
    load_net(np, np, 1'b0, 8'h00);
    expect_result("R6", np);
  endtask

  // R7 R2: empty network fails first at vector 1
  task automatic t_empty();
    load_net(0, 0, 1'b0, 8'h00);
    wait_done("R7");
    check(fail === 1'b1, "R7", "empty net fail", int'(fail), 1);
    check(int'(fail_vec) == 1, "R7", "empty net fail_vec", int'(fail_vec), 1);
  endtask

  // R7: one missing comparator, first failure from the model
  task automatic t_drop_last();
    int np;
    make_bubble(np);
    load_net(np - 1, np - 1, 1'b0, 8'h00);
    expect_result("R7", np - 1);
  endtask

  // R4: same comparators with the last one moved to the front
  task automatic t_order();
    int np, ta, tb;
    make_bubble(np);
    ta = pa[np-1];
    tb = pb[np-1];
    for (int k = np - 1; k > 0; k--) begin
      pa[k] = pa[k-1];
      pb[k] = pb[k-1];
    end
    pa[0] = ta;
    pb[0] = tb;
    load_net(np, np, 1'b0, 8'h00);
    expect_result("R4", np);
  endtask

  // R3 R2: swapped index bytes with high bits set still sort
  task automatic t_swap();
    int np;
    make_bubble(np);
    load_net(np, np, 1'b1, 8'hF8);
    expect_result("R3", np);
  endtask

  // R3: equal-index comparators do nothing
  task automatic t_self();
    for (int k = 0; k < 10; k++) begin
      pa[k] = k % N;
      pb[k] = k % N;
    end
    load_net(10, 10, 1'b0, 8'h00);
    wait_done("R3");
    check(fail === 1'b1, "R3", "self comparators fail", int'(fail), 1);
    check(int'(fail_vec) == 1, "R3", "self comparators fail_vec", int'(fail_vec), 1);
  endtask

  // R8: a load command during a scan is ignored
  task automatic t_busy_start();
    int np;
    make_bubble(np);
    load_net(np, np, 1'b0, 8'h00);
    send_byte(8'h5A);
    send_byte(8'h00);
    wait_done("R8");
    check(pass === 1'b1, "R8", "pass despite mid-scan start", int'(pass), 1);
    check(fail === 1'b0, "R8", "no fail after mid-scan start", int'(fail), 0);
  endtask

  // R10 R2: idle bytes keep the verdict, a new scan clears it
  task automatic t_hold();
    send_byte(8'h13);
    send_byte(8'h00);
    repeat (10) @(negedge clk);
    check(done === 1'b1, "R10", "done held over idle bytes", int'(done), 1);
    check(pass === 1'b1, "R10", "pass held over idle bytes", int'(pass), 1);
    load_net(0, 0, 1'b0, 8'h00);
    check(done === 1'b0, "R10", "done cleared at scan start", int'(done), 0);
    check(pass === 1'b0, "R10", "pass cleared at scan start", int'(pass), 0);
    wait_done("R10");
    check(int'(fail_vec) == 1, "R10", "new scan verdict", int'(fail_vec), 1);
  endtask

  // R9: an oversized count is cut to MAX_CMP
  task automatic t_clamp();
    int np;
    make_bubble(np);
    for (int k = np; k < M; k++) begin
      pa[k] = 0;
      pb[k] = 1;
    end
    load_net(200, M, 1'b0, 8'h00);
    expect_result("R9", M);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!over) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bubble();
    t_empty();
    t_drop_last();
    t_order();
    t_swap();
    t_self();
    t_busy_start();
    t_hold();
    t_clamp();
    over = 1'b1;
    report();
    $finish;
  end

endmodule